// File: doc/BRIEF.md
# Notone and Interval Timer Unit

This block provides the two timers that a tone-signalling receiver and transmitter need. Both timers run from one shared base tick. The first is a one-shot *notone* timer. A period code written by the host primes it, but it does not start counting until the tone decoder reports a successful frequency measurement. Each later successful measurement starts its count again. When it runs out, it reports that no usable tone has arrived for the programmed time. The second is an *interval* timer. Writing its code starts it, and it reloads itself after every expiry, so it paces transmit periods without further host action.

The base tick is one 10 ms unit in the high and extended bands and 20 ms in the mid band. A notone code therefore means code x 20 ms (high) or code x 40 ms (mid). An interval code means code x 10 ms (high) or code x 20 ms (mid). Each expiry sets a sticky status flag. A third flag records completed measurements. An active-low interrupt request combines these flags with two enable inputs. Reading status clears all flags, which releases the interrupt. A general reset strobe returns everything to its power-up state. The serial host interface that produces the strobes lies outside this block.

The notone timer has a special case for a measurement that is more than 75% complete when the timer runs out. Its expiry is then held back. It is reported only if that measurement is later aborted. If the measurement completes instead, the expiry is dropped and the timer restarts.

Top module: `ntu_timer_unit`

## Requirements
- R1: The base tick period is TICK_CYCLES clocks when band_sel is 00 (high) or 10 (extended), and 2*TICK_CYCLES clocks when band_sel is 01 (mid). The value 11 behaves like high.
- R2: nt_wr loads the notone code from wr_data[3:0] (upper bits ignored) and puts the notone FSM in NT_WAIT. In NT_WAIT no expiry occurs, however long it waits. A meas_done pulse moves it to NT_RUN with a load of code x 2 base ticks.
- R3: In NT_RUN every meas_done restarts the count from the full load. When the count runs out, status[1] is set once and the FSM moves to NT_DONE, where it stays (one-shot) until the next meas_done or nt_wr.
- R4: If meas_late is high when the notone count runs out, the FSM moves to NT_HOLD and status[1] is not set. In NT_HOLD, meas_abort sets status[1] and moves to NT_DONE, while meas_done cancels the expiry and restarts NT_RUN.
- R5: gp_wr loads the interval code from wr_data[3:0] and restarts the count at code base ticks in GP_COUNT. When the count reaches zero the FSM enters GP_EXPIRE, sets status[2], reloads the code and returns to GP_COUNT, and it repeats this without end.
- R6: An interval code of 0 keeps the FSM in GP_EXPIRE, so status[2] is set again on every clock and a status read cannot keep it clear. The reset state is code 0.
- R7: status_rd clears all three flags. nt_wr clears status[1] and gp_wr clears status[2]. greset or rst_n clears all flags and both codes and puts the notone FSM in NT_WAIT and the interval FSM in GP_COUNT with count 0. A flag set in the same clock as a clear stays set.
- R8: meas_done sets status[0] on the next clock edge. Only status_rd or a reset clears it.
- R9: irq_n is low exactly when (gp_irq_en and status[2]) or (dec_irq_en and (status[1] or status[0])) holds. The enable inputs never change the status flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| greset | input | 1 | Synchronous general reset strobe |
| band_sel | input | 2 | 00 high, 01 mid, 10 extended |
| meas_done | input | 1 | Successful tone measurement strobe |
| meas_abort | input | 1 | Measurement aborted strobe |
| meas_late | input | 1 | Current measurement is more than 75% complete |
| nt_wr | input | 1 | Notone code write strobe |
| gp_wr | input | 1 | Interval code write strobe |
| wr_data | input | DATA_W | Write byte; low CODE_W bits hold the code |
| status_rd | input | 1 | Status read strobe |
| gp_irq_en | input | 1 | Interval interrupt enable |
| dec_irq_en | input | 1 | Decoder (notone, measurement) interrupt enable |
| status | output | 3 | {interval expired, notone expired, measurement complete} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the unit with TICK_CYCLES = 3 and keeps the default 4-bit codes. With these values a full-scale 15-code notone period in the mid band takes under 200 clocks. That makes multiple reloads, restarts, held expiries and the difference between a 3-clock and a 6-clock base all observable in a short run. A cycle model in the bench, driven by the same random strobes, checks the exact flag timing. This includes coincident set and clear and band changes in the middle of a count.

// File: rtl/ntu_pkg.sv
package ntu_pkg;
    typedef enum logic [1:0] {NT_WAIT, NT_RUN, NT_HOLD, NT_DONE} nt_state_t;
    typedef enum logic {GP_COUNT, GP_EXPIRE} gp_state_t;
    localparam logic [1:0] BAND_MID = 2'b01;
endpackage

// File: rtl/ntu_tick_gen.sv
module ntu_tick_gen #(
    parameter int TICK_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       greset,
    input  logic [1:0] band_sel,
    output logic       tick
);
    import ntu_pkg::*;
    localparam int PW = $clog2(2 * TICK_CYCLES + 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    always_comb begin
        if (band_sel == BAND_MID) limit = PW'(2 * TICK_CYCLES - 1);
        else                      limit = PW'(TICK_CYCLES - 1);
    end

    assign tick = (pcnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pcnt <= '0;
        else if (greset || tick)  pcnt <= '0;
        else                      pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/ntu_notone_fsm.sv
module ntu_notone_fsm #(
    parameter int CODE_W  = 4,
    parameter int NT_MULT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              greset,
    input  logic              tick,
    input  logic              wr,
    input  logic [CODE_W-1:0] code_in,
    input  logic              meas_done,
    input  logic              meas_abort,
    input  logic              meas_late,
    output logic              expire
);
    import ntu_pkg::*;
    localparam int CW = $clog2((2**CODE_W - 1) * NT_MULT + 1);

    nt_state_t         state, state_d;
    logic [CW-1:0]     cnt, cnt_d;
    logic [CODE_W-1:0] code, code_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= NT_WAIT;
            cnt   <= '0;
            code  <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            code  <= code_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        code_d  = code;
        if (greset) begin
            state_d = NT_WAIT;
            cnt_d   = '0;
            code_d  = '0;
        end else if (wr) begin
            state_d = NT_WAIT;
            cnt_d   = '0;
            code_d  = code_in;
        end else if (meas_done) begin
            state_d = NT_RUN;
            cnt_d   = CW'(code) * CW'(NT_MULT);
        end else begin
            unique case (state)
                NT_RUN: begin
                    if (cnt == '0)  state_d = meas_late ? NT_HOLD : NT_DONE;
                    else if (tick)  cnt_d = cnt - 1'b1;
                end
                NT_HOLD: begin
                    if (meas_abort) state_d = NT_DONE;
                end
                NT_WAIT, NT_DONE: begin
                    state_d = state;
                end
            endcase
        end
    end

    always_comb begin
        expire = 1'b0;
        if (!greset && !wr && !meas_done) begin
            unique case (state)
                NT_RUN:           expire = (cnt == '0) && !meas_late;
                NT_HOLD:          expire = meas_abort;
                NT_WAIT, NT_DONE: expire = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ntu_interval_fsm.sv
module ntu_interval_fsm #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              greset,
    input  logic              tick,
    input  logic              wr,
    input  logic [CODE_W-1:0] code_in,
    output logic              expire
);
    import ntu_pkg::*;

    gp_state_t         state, state_d;
    logic [CODE_W-1:0] cnt, cnt_d;
    logic [CODE_W-1:0] code, code_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GP_COUNT;
            cnt   <= '0;
            code  <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            code  <= code_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        code_d  = code;
        if (greset) begin
            state_d = GP_COUNT;
            cnt_d   = '0;
            code_d  = '0;
        end else if (wr) begin
            state_d = GP_COUNT;
            cnt_d   = code_in;
            code_d  = code_in;
        end else begin
            unique case (state)
                GP_COUNT: begin
                    if (cnt == '0) state_d = GP_EXPIRE;
                    else if (tick) cnt_d = cnt - 1'b1;
                end
                GP_EXPIRE: begin
                    cnt_d = code;
                    if (code != '0) state_d = GP_COUNT;
                end
            endcase
        end
    end

    always_comb begin
        expire = (state == GP_EXPIRE) && !greset && !wr;
    end
endmodule

// File: rtl/ntu_timer_unit.sv
module ntu_timer_unit #(
    parameter int TICK_CYCLES = 500000,
    parameter int DATA_W      = 8,
    parameter int CODE_W      = 4,
    parameter int NT_MULT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              greset,
    input  logic [1:0]        band_sel,
    input  logic              meas_done,
    input  logic              meas_abort,
    input  logic              meas_late,
    input  logic              nt_wr,
    input  logic              gp_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              status_rd,
    input  logic              gp_irq_en,
    input  logic              dec_irq_en,
    output logic [2:0]        status,
    output logic              irq_n
);
    logic tick;
    logic nt_fire;
    logic gp_fire;

    ntu_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .greset(greset),
        .band_sel(band_sel), .tick(tick)
    );

    ntu_notone_fsm #(.CODE_W(CODE_W), .NT_MULT(NT_MULT)) u_notone (
        .clk(clk), .rst_n(rst_n), .greset(greset), .tick(tick),
        .wr(nt_wr), .code_in(wr_data[CODE_W-1:0]),
        .meas_done(meas_done), .meas_abort(meas_abort),
        .meas_late(meas_late), .expire(nt_fire)
    );

    ntu_interval_fsm #(.CODE_W(CODE_W)) u_interval (
        .clk(clk), .rst_n(rst_n), .greset(greset), .tick(tick),
        .wr(gp_wr), .code_in(wr_data[CODE_W-1:0]), .expire(gp_fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (greset) begin
            status <= '0;
        end else begin
            status[0] <= meas_done | (status[0] & ~status_rd);
            status[1] <= nt_fire   | (status[1] & ~status_rd & ~nt_wr);
            status[2] <= gp_fire   | (status[2] & ~status_rd & ~gp_wr);
        end
    end

    assign irq_n = ~((gp_irq_en & status[2]) | (dec_irq_en & (status[1] | status[0])));
endmodule

// File: rtl/ntu_timer_unit_chk.sv
module ntu_timer_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       greset,
    input logic       meas_done,
    input logic       meas_abort,
    input logic       meas_late,
    input logic       nt_wr,
    input logic       gp_wr,
    input logic       status_rd,
    input logic       gp_irq_en,
    input logic       dec_irq_en,
    input logic [2:0] status,
    input logic       irq_n,
    input logic       nt_fire,
    input logic       gp_fire
);
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gp_irq_en && !dec_irq_en) |-> irq_n); // R9
    AST_IRQ_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_irq_en && status[2]) |-> !irq_n); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !greset && !meas_done && !nt_fire && !gp_fire) |=> (status == 3'b000)); // R7
    AST_GRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        greset |=> (status == 3'b000)); // R7
    AST_NT_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_wr && !greset) |=> !status[1]); // R7
    AST_MEAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && !greset) |=> status[0]); // R8
    AST_INTERVAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fire |=> status[2]); // R5
    AST_NT_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(!meas_late || meas_abort)); // R4
endmodule

bind ntu_timer_unit ntu_timer_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .greset(greset),
    .meas_done(meas_done), .meas_abort(meas_abort), .meas_late(meas_late),
    .nt_wr(nt_wr), .gp_wr(gp_wr), .status_rd(status_rd),
    .gp_irq_en(gp_irq_en), .dec_irq_en(dec_irq_en),
    .status(status), .irq_n(irq_n), .nt_fire(nt_fire), .gp_fire(gp_fire)
);

// File: tb/tb_ntu_timer_unit.sv
module tb_ntu_timer_unit;
    localparam int TK = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       greset = 1'b0;
    logic [1:0] band_sel = 2'b00;
    logic       meas_done = 1'b0, meas_abort = 1'b0, meas_late = 1'b0;
    logic       nt_wr = 1'b0, gp_wr = 1'b0, status_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       gp_irq_en = 1'b0, dec_irq_en = 1'b0;
    logic [2:0] status;
    logic       irq_n;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string tag = "R7";

    always #10 clk = ~clk;

    ntu_timer_unit #(.TICK_CYCLES(TK)) dut (
        .clk(clk), .rst_n(rst_n), .greset(greset), .band_sel(band_sel),
        .meas_done(meas_done), .meas_abort(meas_abort), .meas_late(meas_late),
        .nt_wr(nt_wr), .gp_wr(gp_wr), .wr_data(wr_data), .status_rd(status_rd),
        .gp_irq_en(gp_irq_en), .dec_irq_en(dec_irq_en),
        .status(status), .irq_n(irq_n)
    );

    // reference model built from the requirements
    int m_pc, m_ns, m_nc, m_ncode, m_gs, m_gc, m_gcode, m_lim;
    bit m_tk, m_nset, m_gset;
    logic [2:0] m_st;

    function automatic logic exp_irq(logic [2:0] st, logic ge, logic de);
        return ~((ge & st[2]) | (de & (st[1] | st[0])));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0; m_ns = 0; m_nc = 0; m_ncode = 0;
            m_gs = 0; m_gc = 0; m_gcode = 0; m_st = 3'b000;
        end else begin
            m_lim  = (band_sel == 2'b01) ? 2 * TK - 1 : TK - 1;
            m_tk   = (m_pc >= m_lim);
            m_nset = !greset && !nt_wr && !meas_done &&
                     ((m_ns == 1 && m_nc == 0 && !meas_late) || (m_ns == 2 && meas_abort));
            m_gset = !greset && !gp_wr && (m_gs == 1);
            if (greset) m_st = 3'b000;
            else begin
                m_st[0] = meas_done | (m_st[0] & !status_rd);
                m_st[1] = m_nset | (m_st[1] & !status_rd & !nt_wr);
                m_st[2] = m_gset | (m_st[2] & !status_rd & !gp_wr);
            end
            m_pc = (greset || m_tk) ? 0 : m_pc + 1;
            // notone: 0 wait, 1 run, 2 hold, 3 done
            if (greset) begin m_ns = 0; m_nc = 0; m_ncode = 0; end
            else if (nt_wr) begin m_ns = 0; m_nc = 0; m_ncode = int'(wr_data[3:0]); end
            else if (meas_done) begin m_ns = 1; m_nc = 2 * m_ncode; end
            else if (m_ns == 1) begin
                if (m_nc == 0) m_ns = meas_late ? 2 : 3;
                else if (m_tk) m_nc = m_nc - 1;
            end else if (m_ns == 2 && meas_abort) m_ns = 3;
            // interval: 0 count, 1 expire
            if (greset) begin m_gs = 0; m_gc = 0; m_gcode = 0; end
            else if (gp_wr) begin m_gs = 0; m_gc = int'(wr_data[3:0]); m_gcode = m_gc; end
            else if (m_gs == 0) begin
                if (m_gc == 0) m_gs = 1;
                else if (m_tk) m_gc = m_gc - 1;
            end else begin
                m_gc = m_gcode;
                if (m_gcode != 0) m_gs = 0;
            end
        end
    end

    always @(negedge clk) begin
        #5;
        if (!finished) begin
            n_chk++;
            if (status !== m_st || irq_n !== exp_irq(m_st, gp_irq_en, dec_irq_en)) begin
                n_fail++;
                $display("FAIL %s model: status=%b irq_n=%b expected status=%b irq_n=%b",
                         tag, status, irq_n, m_st, exp_irq(m_st, gp_irq_en, dec_irq_en));
            end
        end
    end

    task automatic chk(string t, logic [3:0] got, logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", t, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();
        status_rd = 1'b1; cyc(1); status_rd = 1'b0;
    endtask

    task automatic pulse_meas();
        meas_done = 1'b1; cyc(1); meas_done = 1'b0;
    endtask

    task automatic write_gp(logic [3:0] code);
        wr_data = {4'($urandom), code}; gp_wr = 1'b1; cyc(1); gp_wr = 1'b0;
    endtask

    task automatic write_nt(logic [3:0] code);
        wr_data = {4'($urandom), code}; nt_wr = 1'b1; cyc(1); nt_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0803));
        cyc(3);
        tag = "R7";
        chk("R7 reset status", {1'b0, status}, 4'h0);
        chk("R9 reset irq_n", {3'b0, irq_n}, 4'h1);
        rst_n = 1'b1;
        cyc(3);
        tag = "R6";
        chk("R6 code0 after reset", {3'b0, status[2]}, 4'h1);
        chk("R9 masked irq_n", {3'b0, irq_n}, 4'h1);
        pulse_rd();
        chk("R6 permanent despite read", {3'b0, status[2]}, 4'h1);
        tag = "R9";
        gp_irq_en = 1'b1; #1;
        chk("R9 interval irq", {3'b0, irq_n}, 4'h0);
        gp_irq_en = 1'b0;

        tag = "R5";
        write_gp(4'd4);
        cyc(4);
        chk("R5 not yet expired", {3'b0, status[2]}, 4'h0);
        cyc(15);
        chk("R5 expired", {3'b0, status[2]}, 4'h1);
        pulse_rd();
        cyc(18);
        chk("R5 reload expiry", {3'b0, status[2]}, 4'h1);

        tag = "R1";
        band_sel = 2'b01;
        write_gp(4'd4);
        cyc(16);
        chk("R1 mid band slower", {3'b0, status[2]}, 4'h0);
        cyc(13);
        chk("R1 mid band expired", {3'b0, status[2]}, 4'h1);
        band_sel = 2'b10;
        write_gp(4'd4);
        cyc(16);
        chk("R1 extended uses high base", {3'b0, status[2]}, 4'h1);
        band_sel = 2'b00;
        write_gp(4'd15);

        tag = "R2";
        write_nt(4'd2);
        cyc(60);
        chk("R2 not armed without measurement", {3'b0, status[1]}, 4'h0);
        tag = "R8";
        pulse_meas();
        chk("R8 measurement flag", {3'b0, status[0]}, 4'h1);
        tag = "R3";
        cyc(7);
        pulse_meas();
        cyc(7);
        chk("R3 restarted by measurement", {3'b0, status[1]}, 4'h0);
        cyc(13);
        chk("R3 notone expired", {3'b0, status[1]}, 4'h1);
        pulse_rd();
        cyc(60);
        chk("R3 one-shot no reload", {3'b0, status[1]}, 4'h0);

        tag = "R9";
        dec_irq_en = 1'b1;
        pulse_meas();
        chk("R9 decoder irq", {3'b0, irq_n}, 4'h0);
        dec_irq_en = 1'b0; #1;
        chk("R9 enable leaves status", {2'b0, irq_n, status[0]}, 4'h3);

        tag = "R4";
        pulse_rd();
        meas_late = 1'b1;
        pulse_meas();
        cyc(40);
        chk("R4 held while late", {3'b0, status[1]}, 4'h0);
        meas_abort = 1'b1; cyc(1); meas_abort = 1'b0;
        chk("R4 abort releases expiry", {3'b0, status[1]}, 4'h1);
        pulse_rd();
        pulse_meas();
        cyc(40);
        pulse_meas();
        cyc(1);
        chk("R4 completion cancels expiry", {3'b0, status[1]}, 4'h0);
        meas_late = 1'b0;
        cyc(20);
        chk("R4 expires after restart", {3'b0, status[1]}, 4'h1);

        tag = "R7";
        write_nt(4'd2);
        chk("R7 write clears notone flag", {3'b0, status[1]}, 4'h0);
        greset = 1'b1; cyc(1); greset = 1'b0;
        chk("R7 general reset clears", {1'b0, status}, 4'h0);

        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            meas_done  = ($urandom_range(0, 7) == 0);
            meas_abort = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 15) == 0) meas_late = ~meas_late;
            nt_wr      = ($urandom_range(0, 47) == 0);
            gp_wr      = ($urandom_range(0, 31) == 0);
            wr_data    = 8'($urandom);
            status_rd  = ($urandom_range(0, 9) == 0);
            greset     = ($urandom_range(0, 199) == 0);
            gp_irq_en  = ($urandom_range(0, 3) != 0);
            dec_irq_en = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 127) == 0) band_sel = 2'($urandom);
            cyc(1);
        end
        meas_done = 1'b0; meas_abort = 1'b0; nt_wr = 1'b0; gp_wr = 1'b0;
        status_rd = 1'b0; greset = 1'b0;
        cyc(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule